// File: doc/BRIEF.md
# SATA Port Interface Control and Status Registers

This block holds the two per-port interface registers of a SATA host port: a read/write control register and a read-only status register. A simple register bus with separate read and write strobes reaches both registers. The status register encodes a set of PHY-side conditions into three 4-bit fields. These conditions are device presence, link established (phygood), negotiated rate, interface power state, and an offline/loopback flag. The encoding applies forced-zero rules, so speed and power state read as zero whenever the link is not up.

The control register carries two fields. The detection-action field at bits 3:0 drives a small sequencer. When software writes code 0001 there, the block raises a one-cycle reset request toward the PHY, and then raises it again every `RST_PERIOD` clocks until software writes any other code. The speed-limit field at bits 7:4 is decoded into a speed cap output for the negotiation logic. The block does not perform out-of-band signalling, negotiation or power handshakes. It only encodes, exposes and requests.

Top module: `sata_port_regs`

## Requirements
- R1: After reset, both registers read 0x0000_0000, `comreset_req` is low and `speed_cap` is 0000.
- R2: The control register is at byte offset 0x1F00. Bits 7:0 read back as written and bits 31:8 always read zero. The status register is at offset 0x1F04 and its bits 31:12 always read zero.
- R3: Status bits 3:0 encode detection. They read 0100 when `phy_offline` is high, whatever the other inputs are. Otherwise they read 0011 when `phy_linkup` is high, 0001 when only `phy_present` is high, and 0000 when both are low.
- R4: Status bits 7:4 report speed. They read 0001 for `phy_rate`=01 and 0010 for `phy_rate`=10, and 0000 for the other two rate codes. They also read 0000 whenever `phy_linkup` is low or `phy_offline` is high.
- R5: Status bits 11:8 report power state. They read 0001 for `phy_pwr`=00 (active), 0010 for 01 (partial) and 0110 for 10 (slumber), and 0000 for 11. They also read 0000 whenever `phy_linkup` is low or `phy_offline` is high.
- R6: A write of 0001 to control bits 3:0 makes `comreset_req` high for exactly the one cycle after the write. While that code stays, the request repeats as a one-cycle pulse every `RST_PERIOD` clocks.
- R7: A write of any other code to control bits 3:0 drops `comreset_req` from the next cycle on and clears the interval counter. A fresh write of 0001 restarts the pulse train from its first pulse.
- R8: `speed_cap` follows control bits 7:4. It is 0001 for code 0001 (first generation only), 0010 for code 0010 (up to second generation), and 0000 (no limit) for 0000 and every reserved code.
- R9: `bus_rdata` holds the addressed register one cycle after a read strobe. Any other offset reads zero. Writes to the status offset or to unmapped offsets change no register.
- R10: The status register samples the PHY inputs on every clock, so a change of the inputs is visible to a read issued one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| phy_present | input | 1 | Device presence detected |
| phy_linkup | input | 1 | PHY communication established (phygood) |
| phy_rate | input | 2 | Negotiated rate: 01 first gen, 10 second gen |
| phy_pwr | input | 2 | Power state: 00 active, 01 partial, 10 slumber, 11 none |
| phy_offline | input | 1 | Interface disabled or in loopback |
| comreset_req | output | 1 | One-cycle reset request pulse to the PHY |
| speed_cap | output | 4 | Speed limit toward negotiation |

## Verification
The assertions check four properties on every cycle. Each reset request is a single cycle wide, and a request is only raised while the detection code is 0001. The speed cap never takes a reserved value. The status fields keep their forced-zero rules: speed and power read zero unless detection reads 0011, and the reserved upper status bits stay zero. The bench scenarios cover what needs a history to judge. These are the exact spacing of pulses after a write, an immediate stop when the code changes, restart on a repeated write, the one-cycle read latency, and the fact that writes to the status offset have no effect.

// File: rtl/sata_port_regs.sv
module sata_port_regs #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int RST_PERIOD = 64,
  parameter logic [ADDR_W-1:0] CTL_OFS = 16'h1F00,
  parameter logic [ADDR_W-1:0] STS_OFS = 16'h1F04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              phy_present,
  input  logic              phy_linkup,
  input  logic [1:0]        phy_rate,
  input  logic [1:0]        phy_pwr,
  input  logic              phy_offline,
  output logic              comreset_req,
  output logic [3:0]        speed_cap
);
  localparam int CW = (RST_PERIOD > 2) ? $clog2(RST_PERIOD) : 1;

  logic [7:0]    ctl_q;
  logic [11:0]   sts_q;
  logic [CW-1:0] gap_cnt;
  logic [3:0]    det_n, spd_n, ipm_n;
  logic          link_ok;

  wire ctl_wr   = bus_wr && (bus_addr == CTL_OFS);
  wire [3:0] ctl_det = ctl_q[3:0];
  wire [3:0] ctl_spd = ctl_q[7:4];
  wire unused_wdata = &{1'b0, bus_wdata[DATA_W-1:8]};

  assign link_ok = phy_linkup && !phy_offline;

  always_comb begin
    if (phy_offline)      det_n = 4'b0100;
    else if (phy_linkup)  det_n = 4'b0011;
    else if (phy_present) det_n = 4'b0001;
    else                  det_n = 4'b0000;
  end

  always_comb begin
    spd_n = 4'b0000;
    if (link_ok)
      case (phy_rate)
        2'b01:   spd_n = 4'b0001;
        2'b10:   spd_n = 4'b0010;
        default: spd_n = 4'b0000;
      endcase
  end

  always_comb begin
    ipm_n = 4'b0000;
    if (link_ok)
      case (phy_pwr)
        2'b00:   ipm_n = 4'b0001;
        2'b01:   ipm_n = 4'b0010;
        2'b10:   ipm_n = 4'b0110;
        default: ipm_n = 4'b0000;
      endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= {ipm_n, spd_n, det_n};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_wr) ctl_q <= bus_wdata[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt      <= '0;
      comreset_req <= 1'b0;
    end else if (ctl_wr) begin
      gap_cnt      <= '0;
      comreset_req <= (bus_wdata[3:0] == 4'b0001);
    end else if (ctl_det == 4'b0001) begin
      if (gap_cnt == CW'(RST_PERIOD - 1)) begin
        gap_cnt      <= '0;
        comreset_req <= 1'b1;
      end else begin
        gap_cnt      <= gap_cnt + 1'b1;
        comreset_req <= 1'b0;
      end
    end else begin
      gap_cnt      <= '0;
      comreset_req <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) begin
      if (bus_addr == CTL_OFS)      bus_rdata <= DATA_W'(ctl_q);
      else if (bus_addr == STS_OFS) bus_rdata <= DATA_W'(sts_q);
      else                          bus_rdata <= '0;
    end
  end

  assign speed_cap = (ctl_spd == 4'b0001 || ctl_spd == 4'b0010) ? ctl_spd : 4'b0000;
endmodule

module sata_port_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        comreset_req,
  input logic [3:0]  speed_cap,
  input logic [3:0]  ctl_det,
  input logic [11:0] sts_q,
  input logic [31:0] bus_rdata,
  input logic        rd_sts
);
  // R6
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    comreset_req |=> !comreset_req);
  // R6
  pulse_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    comreset_req |-> (ctl_det == 4'b0001));
  // R8
  speed_cap_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    speed_cap == 4'b0000 || speed_cap == 4'b0001 || speed_cap == 4'b0010);
  // R4
  spd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q[3:0] != 4'b0011) |-> (sts_q[7:4] == 4'b0000));
  // R5
  ipm_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q[3:0] != 4'b0011) |-> (sts_q[11:8] == 4'b0000));
  // R2
  sts_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sts |=> (bus_rdata[31:12] == 20'h0));
endmodule

bind sata_port_regs sata_port_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .comreset_req(comreset_req), .speed_cap(speed_cap),
  .ctl_det(ctl_q[3:0]), .sts_q(sts_q), .bus_rdata(bus_rdata),
  .rd_sts(bus_rd && bus_addr == 16'h1F04)
);

// File: tb/sata_port_regs_tb.sv
module sata_port_regs_tb;
  localparam int P = 8;
  localparam logic [15:0] CTL = 16'h1F00, STS = 16'h1F04;

  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic phy_present = 0, phy_linkup = 0, phy_offline = 0, comreset_req;
  logic [1:0] phy_rate = 0, phy_pwr = 0;
  logic [3:0] speed_cap;
  int checks = 0, fails = 0;
  logic [31:0] rv;

  sata_port_regs #(.RST_PERIOD(P)) u_dut (.*);

  always #10 clk = ~clk;

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  function automatic logic [31:0] exp_sts(logic pr, logic lu, logic [1:0] rt, logic [1:0] pw, logic off);
    logic [3:0] d, s, i;
    d = off ? 4'b0100 : lu ? 4'b0011 : pr ? 4'b0001 : 4'b0000;
    s = 4'b0000; i = 4'b0000;
    if (lu && !off) begin
      s = (rt == 2'b01) ? 4'b0001 : (rt == 2'b10) ? 4'b0010 : 4'b0000;
      i = (pw == 2'b00) ? 4'b0001 : (pw == 2'b01) ? 4'b0010 : (pw == 2'b10) ? 4'b0110 : 4'b0000;
    end
    return {20'h0, i, s, d};
  endfunction

  function automatic logic [3:0] exp_cap(logic [3:0] c);
    return (c == 4'b0001 || c == 4'b0010) ? c : 4'b0000;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic set_phy(logic pr, logic lu, logic [1:0] rt, logic [1:0] pw, logic off);
    @(negedge clk);
    phy_present = pr; phy_linkup = lu; phy_rate = rt; phy_pwr = pw; phy_offline = off;
  endtask

  task automatic sts_case(string req, logic pr, logic lu, logic [1:0] rt, logic [1:0] pw, logic off);
    set_phy(pr, lu, rt, pw, off);
    rd(STS, rv);
    chk(req, rv, exp_sts(pr, lu, rt, pw, off));
  endtask

  initial begin
    void'($urandom(32'h5A7A_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 comreset", {31'h0, comreset_req}, 0);
    chk("R1 speed_cap", {28'h0, speed_cap}, 0);
    rd(CTL, rv); chk("R1 ctl", rv, 0);
    rd(STS, rv); chk("R1 sts", rv, 0);

    // R2 control readback, upper bits zero
    wr(CTL, 32'hFFFF_FF24);
    rd(CTL, rv); chk("R2 ctl readback", rv, 32'h0000_0024);
    // R8 speed cap decoding
    chk("R8 cap 2", {28'h0, speed_cap}, 4'b0010);
    wr(CTL, 32'h10); chk("R8 cap 1", {28'h0, speed_cap}, 4'b0001);
    wr(CTL, 32'h70); chk("R8 reserved", {28'h0, speed_cap}, 4'b0000);

    // R9 writes to status / unmapped ignored, unmapped reads zero
    set_phy(1, 1, 2'b10, 2'b01, 0);
    wr(STS, 32'hFFFF_FFFF);
    wr(16'h1F08, 32'hFF);
    rd(STS, rv); chk("R9 sts write ignored", rv, exp_sts(1, 1, 2'b10, 2'b01, 0));
    rd(CTL, rv); chk("R9 ctl untouched", rv, 32'h70);
    rd(16'h1F08, rv); chk("R9 unmapped read", rv, 0);

    // R3 R4 R5 directed corners
    sts_case("R3 offline priority", 1, 1, 2'b10, 2'b00, 1);
    sts_case("R3 present only", 1, 0, 2'b01, 2'b00, 0);
    sts_case("R3 none", 0, 0, 2'b10, 2'b10, 0);
    sts_case("R4 gen1", 1, 1, 2'b01, 2'b11, 0);
    sts_case("R4 reserved rate", 1, 1, 2'b11, 2'b00, 0);
    sts_case("R5 slumber", 1, 1, 2'b10, 2'b10, 0);

    // R10 one-cycle capture: change inputs, read on next cycle
    @(negedge clk); phy_present = 1; phy_linkup = 1; phy_rate = 2'b01; phy_pwr = 2'b00; phy_offline = 0;
    bus_addr = STS;
    @(negedge clk); bus_rd = 1;
    @(negedge clk); bus_rd = 0;
    chk("R10 capture", bus_rdata, exp_sts(1, 1, 2'b01, 2'b00, 0));

    // R3 R4 R5 R10 random
    for (int i = 0; i < 150; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      sts_case("R3/R4/R5 random", r[0], r[1], r[3:2], r[5:4], (r[7:6] == 2'b00));
    end

    // R8 random control writes
    for (int i = 0; i < 40; i++) begin
      logic [3:0] c;
      c = 4'($urandom);
      wr(CTL, {24'h0, c, 4'h0});
      chk("R8 random cap", {28'h0, speed_cap}, {28'h0, exp_cap(c)});
    end

    // R6 pulse train
    @(negedge clk); bus_addr = CTL; bus_wdata = 32'h1; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
    chk("R6 first pulse", {31'h0, comreset_req}, 1);
    for (int k = 1; k <= 3 * P; k++) begin
      @(negedge clk);
      chk("R6 period", {31'h0, comreset_req}, {31'h0, (k % P) == 0});
    end
    // R7 restart mid-interval
    repeat (3) @(negedge clk);
    bus_wdata = 32'h1; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
    chk("R7 restart first", {31'h0, comreset_req}, 1);
    for (int k = 1; k <= P; k++) begin
      @(negedge clk);
      chk("R7 restart period", {31'h0, comreset_req}, {31'h0, k == P});
    end
    // R7 stop on other code, written the cycle before a pulse would fire
    repeat (P - 2) @(negedge clk);
    bus_wdata = 32'h4; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
    chk("R7 stop now", {31'h0, comreset_req}, 0);
    for (int k = 1; k <= 2 * P; k++) begin
      @(negedge clk);
      chk("R7 stays off", {31'h0, comreset_req}, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule